// File: doc/BRIEF.md
# Bit-Vector Compare and Branch Evaluator

This unit compares two integer operands and packs every relation between them into one condition vector. The vector is as wide as a general register and is meant to be written back to any register, so no dedicated flag register is needed. The same unit also decides conditional branches, using one of two forms:

- It picks one bit of a register value and tests whether that bit is set or clear.
- It tests the whole register value, where zero counts as false and any non-zero value counts as true.

Each request arrives with a valid strobe, and the unit registers its result. One cycle after the strobe, the condition vector and the taken flag appear at the outputs together with a one-cycle valid pulse. The outputs then keep their values until the next request.

The compare honours an operation size of 8, 16, 32 or 64 bits. Signed relations sign-extend both operands from that size, and unsigned relations zero-extend them. Target address generation, the register file and the pipeline around the unit are not part of this block.

Top module: `bvcmp_unit`

## Requirements
- R1: While reset is asserted and after reset is released, `valid_o`, `cond_o` and `taken_o` are all zero.
- R2: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high. When `valid_i` is low, `cond_o` and `taken_o` keep their values.
- R3: For a compare (`op_i`=0), `cond_o` holds the following relations, each as 1 when true: bit0 a==b, bit1 a!=b, bit2 signed a<b, bit3 signed a<=b, bit4 signed a>b, bit5 signed a>=b, bit6 unsigned a<b, bit7 unsigned a<=b, bit8 unsigned a>b, bit9 unsigned a>=b. Bits 63:10 are zero.
- R4: `size_i` selects the compare width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Operand bits above the selected width have no effect on `cond_o`.
- R5: Signed relations sign-extend both operands from the selected width. Equality and unsigned relations zero-extend them.
- R6: Branch-if-set (`op_i`=1) sets `taken_o` exactly when bit `bit_idx_i[5:0]` of `opa_i` is 1.
- R7: Branch-if-clear (`op_i`=2) sets `taken_o` exactly when bit `bit_idx_i[5:0]` of `opa_i` is 0.
- R8: Branch-if-true (`op_i`=3) is taken when the full 64-bit `opa_i` is non-zero. Branch-if-false (`op_i`=4) is taken when it is zero. `size_i` is ignored for both.
- R9: A bit index above 63 is reduced to its low 6 bits. For example, index 70 selects bit 6.
- R10: A compare result has `taken_o`=0. Every branch op gives `cond_o`=0. Op codes 5 to 7 give `cond_o`=0 and `taken_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (see R3, R6 to R8, R10) |
| size_i | input | 2 | Compare width code |
| opa_i | input | 64 | First operand; the tested register for branches |
| opb_i | input | 64 | Second operand for compares |
| bit_idx_i | input | 8 | Bit position for the bit-test branches |
| valid_o | output | 1 | Result valid pulse |
| cond_o | output | 64 | Condition vector for write-back |
| taken_o | output | 1 | Branch decision |

## Verification
The bench drives compares where the operands differ only above the selected width. A design that masked the wrong bits would report those operands as unequal. It also uses values whose top bit at the selected width is set, which separates the signed relations from the unsigned ones; if the unit extended the operands the wrong way, bits 2 to 5 would come out flipped. For branches, the bench uses bit indices above 63 to catch an index that is not wrapped to 6 bits. It also checks that zero and non-zero values give the right decision in both whole-register forms, which catches a reversed sense. Finally, it holds `valid_i` low to check that the results are not overwritten while no request is present.

// File: rtl/bvcmp_pkg.sv
package bvcmp_pkg;
  typedef enum logic [2:0] {
    OP_CMP   = 3'd0,
    OP_BSET  = 3'd1,
    OP_BCLR  = 3'd2,
    OP_BTRUE = 3'd3,
    OP_BFALS = 3'd4
  } op_e;

  localparam int unsigned REL_N = 10;
  localparam int unsigned REL_EQ  = 0;
  localparam int unsigned REL_NE  = 1;
  localparam int unsigned REL_SLT = 2;
  localparam int unsigned REL_SLE = 3;
  localparam int unsigned REL_SGT = 4;
  localparam int unsigned REL_SGE = 5;
  localparam int unsigned REL_ULT = 6;
  localparam int unsigned REL_ULE = 7;
  localparam int unsigned REL_UGT = 8;
  localparam int unsigned REL_UGE = 9;
endpackage

// File: rtl/bvcmp_extend.sv
module bvcmp_extend #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] zx_o,
  output logic [DATA_W-1:0] sx_o
);
  logic [6:0] width;
  logic       msb;

  always_comb begin
    width = 7'd8 << size_i;
    msb   = val_i[width - 7'd1];
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(width)) begin
        zx_o[i] = val_i[i];
        sx_o[i] = val_i[i];
      end else begin
        zx_o[i] = 1'b0;
        sx_o[i] = msb;
      end
    end
  end
endmodule

// File: rtl/bvcmp_relations.sv
module bvcmp_relations
  import bvcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] cond_o
);
  logic [DATA_W-1:0] zx [2];
  logic [DATA_W-1:0] sx [2];
  logic [DATA_W-1:0] src [2];

  assign src[0] = opa_i;
  assign src[1] = opb_i;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    bvcmp_extend #(.DATA_W(DATA_W)) u_ext (
      .val_i (src[g]),
      .size_i(size_i),
      .zx_o  (zx[g]),
      .sx_o  (sx[g])
    );
  end

  logic eq, slt, ult;
  assign eq  = (zx[0] == zx[1]);
  assign slt = ($signed(sx[0]) < $signed(sx[1]));
  assign ult = (zx[0] < zx[1]);

  always_comb begin
    cond_o          = '0;
    cond_o[REL_EQ]  = eq;
    cond_o[REL_NE]  = ~eq;
    cond_o[REL_SLT] = slt;
    cond_o[REL_SLE] = slt | eq;
    cond_o[REL_SGT] = ~(slt | eq);
    cond_o[REL_SGE] = ~slt;
    cond_o[REL_ULT] = ult;
    cond_o[REL_ULE] = ult | eq;
    cond_o[REL_UGT] = ~(ult | eq);
    cond_o[REL_UGE] = ~ult;
  end
endmodule

// File: rtl/bvcmp_branch.sv
module bvcmp_branch
  import bvcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned SEL_W = $clog2(DATA_W)
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              taken_o
);
  logic [SEL_W-1:0] sel;
  logic             bit_v, nz;

  assign sel   = idx_i[SEL_W-1:0];  // wrap out-of-range index
  assign bit_v = val_i[sel];
  assign nz    = |val_i;

  always_comb begin
    unique case (op_i)
      OP_BSET:  taken_o = bit_v;
      OP_BCLR:  taken_o = ~bit_v;
      OP_BTRUE: taken_o = nz;
      OP_BFALS: taken_o = ~nz;
      default:  taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bvcmp_unit.sv
module bvcmp_unit
  import bvcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] cond_o,
  output logic              taken_o
);
  logic [DATA_W-1:0] cond_d;
  logic              taken_d;

  bvcmp_relations #(.DATA_W(DATA_W)) u_rel (
    .opa_i (opa_i),
    .opb_i (opb_i),
    .size_i(size_i),
    .cond_o(cond_d)
  );

  bvcmp_branch #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_br (
    .op_i   (op_i),
    .val_i  (opa_i),
    .idx_i  (bit_idx_i),
    .taken_o(taken_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cond_o  <= '0;
      taken_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        cond_o  <= (op_i == OP_CMP) ? cond_d : '0;
        taken_o <= taken_d;
      end
    end
  end
endmodule

// File: rtl/bvcmp_unit_chk.sv
module bvcmp_unit_chk
  import bvcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [IDX_W-1:0]  bit_idx_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] cond_o,
  input logic              taken_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(cond_o) && $stable(taken_o)));
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cond_o[DATA_W-1:REL_N] == '0));
  a_r3_le_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cond_o[REL_SLE] == (cond_o[REL_SLT] | cond_o[REL_EQ])));
  a_r6_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_BSET) |=> (taken_o == $past(opa_i[bit_idx_i[5:0]])));
  a_r8_true_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_BTRUE) |=> (taken_o == ($past(opa_i) != '0)));
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(taken_o && (cond_o != '0)));
endmodule

bind bvcmp_unit bvcmp_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .opa_i    (opa_i),
  .bit_idx_i(bit_idx_i),
  .valid_o  (valid_o),
  .cond_o   (cond_o),
  .taken_o  (taken_o)
);

// File: tb/bvcmp_unit_test.sv
`timescale 1ns/1ps
module bvcmp_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic [7:0]  bit_idx_i = '0;
  logic        valid_o, taken_o;
  logic [63:0] cond_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bvcmp_unit uut (.*);

  function automatic logic [63:0] ref_cond(logic [63:0] a, logic [63:0] b, logic [1:0] sz);
    logic [63:0] m, au, bu, as_, bs_, r;
    int w;
    logic e, sl, ul;
    w = 8 << sz;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    au = a & m;
    bu = b & m;
    as_ = a[w-1] ? (au | ~m) : au;
    bs_ = b[w-1] ? (bu | ~m) : bu;
    e = (au == bu);
    sl = $signed(as_) < $signed(bs_);
    ul = au < bu;
    r = '0;
    r[0] = e; r[1] = !e; r[2] = sl; r[3] = sl || e; r[4] = !sl && !e; r[5] = !sl;
    r[6] = ul; r[7] = ul || e; r[8] = !ul && !e; r[9] = !ul;
    return r;
  endfunction

  function automatic logic ref_taken(logic [2:0] op, logic [63:0] a, logic [7:0] idx);
    case (op)
      3'd1: return a[idx[5:0]];
      3'd2: return !a[idx[5:0]];
      3'd3: return a != 0;
      3'd4: return a == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [2:0] op, logic [1:0] sz, logic [63:0] a,
                     logic [63:0] b, logic [7:0] idx);
    logic [63:0] ec;
    logic et;
    @(negedge clk_i);
    valid_i = 1; op_i = op; size_i = sz; opa_i = a; opb_i = b; bit_idx_i = idx;
    @(negedge clk_i);
    valid_i = 0;
    ec = (op == 3'd0) ? ref_cond(a, b, sz) : 64'd0;
    et = ref_taken(op, a, idx);
    check({req, " R2 valid"}, {63'd0, valid_o}, 64'd1);
    check({req, " cond"}, cond_o, ec);
    check({req, " taken"}, {63'd0, taken_o}, {63'd0, et});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] hc;
    logic ht;
    process::self().srandom(32'd1234);
    #12;
    check("R1 valid_o reset", {63'd0, valid_o}, 64'd0);
    check("R1 cond_o reset", cond_o, 64'd0);
    check("R1 taken_o reset", {63'd0, taken_o}, 64'd0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    check("R1 after release", {62'd0, valid_o, taken_o}, 64'd0);

    // R4: operands differ only above width -> equal
    run("R4 8b upper ignored", 3'd0, 2'd0, 64'hFFFF_0000_0000_1234, 64'h0000_0000_0000_AB34, 8'd0);
    check("R4 eq bit", {63'd0, cond_o[0]}, 64'd1);
    run("R4 16b upper ignored", 3'd1 - 3'd1, 2'd1, 64'h0001_0000_0000_8000, 64'h0000_0000_0001_8000, 8'd0);
    // R5: 0x80 vs 0x01 at 8 bits: signed less, unsigned greater
    run("R5 sign ext 8b", 3'd0, 2'd0, 64'h80, 64'h01, 8'd0);
    check("R5 slt", {63'd0, cond_o[2]}, 64'd1);
    check("R5 ugt", {63'd0, cond_o[8]}, 64'd1);
    run("R5 sign ext 32b", 3'd0, 2'd2, 64'h0000_0000_8000_0000, 64'h0000_0001_7FFF_FFFF, 8'd0);
    run("R3 64b signed min", 3'd0, 2'd3, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 8'd0);
    run("R3 64b equal", 3'd0, 2'd3, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001, 8'd0);
    // R9: index 70 selects bit 6
    run("R9 idx wrap set", 3'd1, 2'd0, 64'h40, 64'd0, 8'd70);
    check("R9 taken", {63'd0, taken_o}, 64'd1);
    run("R7 clear", 3'd2, 2'd0, 64'h8000_0000_0000_0000, 64'd0, 8'd63);
    run("R7 clear wrap", 3'd2, 2'd0, 64'h1, 64'd0, 8'd192);
    run("R8 true zero", 3'd3, 2'd0, 64'd0, 64'd0, 8'd0);
    run("R8 true upper", 3'd3, 2'd0, 64'h0100_0000_0000_0000, 64'd0, 8'd0);
    run("R8 false zero", 3'd4, 2'd0, 64'd0, 64'd0, 8'd0);
    run("R8 false nz", 3'd4, 2'd3, 64'h8000_0000_0000_0000, 64'd0, 8'd0);
    run("R10 op5", 3'd5, 2'd3, 64'd5, 64'd5, 8'd0);
    run("R10 op7", 3'd7, 2'd3, 64'd0, 64'd0, 8'd0);
    run("R6 set", 3'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 8'd0);

    // R2 hold: no request, outputs keep value, no valid pulse
    run("R2 base", 3'd0, 2'd3, 64'd3, 64'd9, 8'd0);
    hc = cond_o; ht = taken_o;
    opa_i = 64'd0; opb_i = 64'd0; op_i = 3'd4;
    @(negedge clk_i);
    check("R2 no pulse", {63'd0, valid_o}, 64'd0);
    check("R2 cond hold", cond_o, hc);
    check("R2 taken hold", {63'd0, taken_o}, {63'd0, ht});

    for (int i = 0; i < 600; i++) begin
      logic [63:0] a, b;
      logic [2:0] op;
      a = {$urandom, $urandom};
      b = ($urandom % 4 == 0) ? a ^ (64'd1 << ($urandom % 64)) : {$urandom, $urandom};
      if ($urandom % 8 == 0) a = 64'd0;
      op = 3'($urandom % 8);
      if ($urandom % 2 == 0) op = 3'd0;
      run("R3/R6 random", op, 2'($urandom), a, b, 8'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule